// File: doc/BRIEF.md
# SPI Target with Frame CRC Checking

This block is the serial front end of a sensor-style target device. A controller exchanges fixed 32-bit frames with it over a four-wire SPI link in mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge), most significant bit first. The lowest four bits of every frame, in both directions, carry a 4-bit CRC. The block checks that CRC on each incoming frame and commits a register write only when the check passes. It builds the CRC of the response as the response bits leave the device.

When the incoming CRC is wrong, the block reports it in two ways. Within the same frame, it inverts the last response bit, provided the fault lies in the received CRC bits that arrive early enough. It also sets a sticky error flag, which appears in the status byte of the next read response. The flag clears once a read that passes its own check has reported it.

The serial pins are oversampled by a system clock `clk`, so all state lives in one clock domain. A simple register-file port gives the write strobe, address and write data, and takes back combinational read data for the address on `rf_addr`.

Top module: `spi_crc_target`

## Requirements
- R1: A frame is exactly 32 SCLK cycles while CS_n is low, MSB first. Incoming bit 31 selects read (1) or write (0), bits [30:24] are the register address, bits [23:8] are write data, bits [7:4] are ignored and bits [3:0] are the CRC. SDI is sampled on the SCLK rising edge. SDO changes after the falling edge, and response bit 31 is valid before the first rising edge.
- R2: The CRC uses polynomial x^4+x+1 with seed 4'b1111. It is taken over frame bits 31 down to 4 followed by four zero bits, MSB first. For each bit, t = bit XOR crc[3], and the new crc is {crc[2], crc[1], crc[0]^t, t}. The same rule is used to check incoming frames and to generate responses.
- R3: A write frame whose received CRC matches gives exactly one `rf_we` pulse after CS_n rises, with `rf_addr` and `rf_wdata` taken from the frame.
- R4: A write frame whose received CRC does not match produces no `rf_we` pulse, and no register changes.
- R5: On a read frame, response bits [23:8] carry `rf_rdata` for the addressed register within the same frame. A write frame returns zero in these bits, and response bits [7:4] are always zero.
- R6: Response bits [31:24] are the status byte. Bit 24 is the sticky CRC-error flag as it stood when CS_n fell, and bits [31:25] are zero. Response bits [3:0] are the correct CRC (R2) of response bits [31:4].
- R7: When any of received bits [3:1] differs from the expected CRC, response bit 0 is driven inverted. A mismatch confined to received bit 0 does not invert it.
- R8: Any CRC mismatch in a complete frame, read or write, including one in bit 0 only, sets the sticky flag.
- R9: The sticky flag clears after a complete read frame that passes its check and reported the flag as 1. Write frames and failing frames leave it set.
- R10: A frame ended by CS_n after any count other than 32 rising edges commits no write and leaves the sticky flag unchanged. The next frame starts cleanly.
- R11: After reset, `sdo` and `rf_we` are 0 and the sticky flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data into the target |
| sdo | output | 1 | Serial data out of the target, low while deselected |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_addr | output | 7 | Register address for reads and writes |
| rf_wdata | output | 16 | Register write data |
| rf_rdata | input | 16 | Read data for the register at `rf_addr` |

## Verification
The hardest case to reach is the split between in-frame signalling and the sticky flag. A fault in received CRC bits [3:1] must flip response bit 0 in that frame. A fault in bit 0 alone arrives too late to flip anything, yet it must still set the flag. The bench produces both by XOR-ing single bits into otherwise valid frames. Across the following frames it then follows how the flag is reported, held through writes and failing reads, and cleared by a passing read. It also cuts a frame short at 16 clocks to show that an aborted frame neither writes nor disturbs the flag.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

   localparam int CRC_W = 4;
   localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;
   localparam logic [CRC_W-1:0] CRC_SEED = 4'b1111;

   // one serial step of the x^4+x+1 divider
   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
      logic fb;
      fb = b ^ c[CRC_W-1];
      return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
   endfunction

   // append CRC_W zero bits to finish the division
   function automatic logic [CRC_W-1:0] crc_flush(input logic [CRC_W-1:0] c);
      logic [CRC_W-1:0] r;
      r = c;
      for (int i = 0; i < CRC_W; i++) r = crc_step(r, 1'b0);
      return r;
   endfunction

endpackage

// File: rtl/spi_crc_sync.sv
module spi_crc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_crc_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_crc_accum.sv
module spi_crc_accum
   import spi_crc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed,
   input  logic             step,
   input  logic             din,
   output logic [CRC_W-1:0] crc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= CRC_SEED;
      else if (seed) crc_q <= CRC_SEED;
      else if (step) crc_q <= crc_step(crc_q, din);
   end
endmodule

// File: rtl/spi_crc_flag.sv
module spi_crc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   // R8
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n) set |=> flag);
   // R9
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr && !set) |=> !flag);
endmodule

// File: rtl/spi_crc_target.sv
module spi_crc_target
   import spi_crc_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 16,
   parameter int CMD_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   output logic              sdo,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata
);
   localparam int HDR_W     = 1 + ADDR_W;
   localparam int FRAME_W   = HDR_W + DATA_W + CMD_W + CRC_W;
   localparam int BODY_W    = FRAME_W - CRC_W;
   localparam int RXS_W     = DATA_W - 1;
   localparam int CNT_W     = $clog2(FRAME_W + 2);
   localparam int CIDX_W    = $clog2(CRC_W);
   localparam logic [CNT_W-1:0] C_HDR   = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] C_DEND  = CNT_W'(HDR_W + DATA_W - 1);
   localparam logic [CNT_W-1:0] C_BODY  = CNT_W'(BODY_W);
   localparam logic [CNT_W-1:0] C_TXCRC = CNT_W'(BODY_W - 1);
   localparam logic [CNT_W-1:0] C_TXLSB = CNT_W'(FRAME_W - 2);
   localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] C_FULL  = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] C_OVER  = CNT_W'(FRAME_W + 1);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("spi_crc_target: ADDR_W must be at least 2");
      end
      if (DATA_W <= ADDR_W) begin : g_bad_data
         $error("spi_crc_target: DATA_W must exceed ADDR_W");
      end
      if (CMD_W < 1) begin : g_bad_cmd
         $error("spi_crc_target: CMD_W must be at least 1");
      end
   endgenerate

   // ---------------- pin synchronisation and edge detection
   logic sclk_s, cs_s, sdi_s;
   logic sclk_d, cs_d;

   spi_crc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
   spi_crc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .dout(cs_s));
   spi_crc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .din(sdi), .dout(sdi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   logic rise, fall, start, stop;
   assign rise  = sclk_s & ~sclk_d & ~cs_s;
   assign fall  = ~sclk_s & sclk_d & ~cs_s;
   assign start = ~cs_s & cs_d;
   assign stop  = cs_s & ~cs_d;

   // ---------------- frame state
   logic [CNT_W-1:0]  rcnt, fcnt;
   logic [RXS_W-1:0]  rx_shift;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;
   logic              mism, lsb_bad, reported;
   logic [FRAME_W-1:0] tx_shift, tx_next;
   logic              sticky;

   // ---------------- CRC engines
   logic [CRC_W-1:0]  rx_crc, tx_crc, rx_exp, tx_crc_out;
   logic [CIDX_W-1:0] crc_idx;

   spi_crc_accum u_rx_crc (
      .clk(clk), .rst_n(rst_n), .seed(start),
      .step(rise && (rcnt < C_BODY)), .din(sdi_s), .crc_q(rx_crc));

   spi_crc_accum u_tx_crc (
      .clk(clk), .rst_n(rst_n), .seed(start),
      .step(fall && (fcnt < C_BODY)), .din(tx_shift[FRAME_W-1]), .crc_q(tx_crc));

   assign rx_exp     = crc_flush(rx_crc);
   assign tx_crc_out = crc_flush(crc_step(tx_crc, tx_shift[FRAME_W-1]));
   assign crc_idx    = CIDX_W'(C_LAST - rcnt);

   // ---------------- receive path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt     <= '0;
         rx_shift <= '0;
         data_q   <= '0;
         addr_q   <= '0;
         rd_q     <= 1'b0;
         mism     <= 1'b0;
         lsb_bad  <= 1'b0;
      end else if (start) begin
         rcnt    <= '0;
         rd_q    <= 1'b0;
         mism    <= 1'b0;
         lsb_bad <= 1'b0;
      end else if (rise) begin
         rx_shift <= {rx_shift[RXS_W-2:0], sdi_s};
         if (rcnt != C_OVER) rcnt <= rcnt + 1'b1;
         if (rcnt == C_HDR) begin
            rd_q   <= rx_shift[ADDR_W-1];
            addr_q <= {rx_shift[ADDR_W-2:0], sdi_s};
         end
         if (rcnt == C_DEND) data_q <= {rx_shift, sdi_s};
         if ((rcnt >= C_BODY) && (rcnt < C_LAST)) mism <= mism | (sdi_s ^ rx_exp[crc_idx]);
         if (rcnt == C_LAST) lsb_bad <= sdi_s ^ rx_exp[0];
      end
   end

   assign rf_addr = addr_q;

   // ---------------- transmit path
   always_comb begin
      tx_next = {tx_shift[FRAME_W-2:0], 1'b0};
      if ((fcnt == C_HDR) && rd_q)  tx_next[FRAME_W-1 -: DATA_W] = rf_rdata;
      if (fcnt == C_TXCRC)          tx_next[FRAME_W-1 -: CRC_W]  = tx_crc_out;
      if (fcnt == C_TXLSB)          tx_next[FRAME_W-1]           = tx_shift[FRAME_W-2] ^ mism;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt     <= '0;
         tx_shift <= '0;
         reported <= 1'b0;
      end else if (start) begin
         fcnt     <= '0;
         tx_shift <= {{(HDR_W-1){1'b0}}, sticky, {(FRAME_W-HDR_W){1'b0}}};
         reported <= sticky;
      end else if (fall) begin
         if (fcnt != C_OVER) fcnt <= fcnt + 1'b1;
         tx_shift <= tx_next;
      end
   end

   assign sdo = tx_shift[FRAME_W-1] & ~cs_s;

   // ---------------- frame completion
   logic full, bad, we_go, flag_set, flag_clr;
   assign full     = stop && (rcnt == C_FULL);
   assign bad      = mism | lsb_bad;
   assign we_go    = full && !bad && !rd_q;
   assign flag_set = full && bad;
   assign flag_clr = full && !bad && rd_q && reported;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rf_we    <= 1'b0;
         rf_wdata <= '0;
      end else begin
         rf_we <= we_go;
         if (we_go) rf_wdata <= data_q;
      end
   end

   spi_crc_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flag(sticky));

   // R3
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> !rf_we);
   // R4
   we_clean_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> !$rose(sticky));
   // R10
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && (rcnt != C_FULL)) |=> (!rf_we && $stable(sticky)));
   // R1
   rcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) (rcnt <= C_OVER) && (fcnt <= C_OVER));
   // R5
   addr_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && (fcnt == C_HDR)) |-> $stable(rf_addr));
endmodule

// File: tb/sim_spi_crc_target.sv
module sim_spi_crc_target;
   localparam int HALF = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, sclk, cs_n, sdi, sdo, rf_we;
   logic [6:0]  rf_addr;
   logic [15:0] rf_wdata, rf_rdata;

   logic [15:0] mem     [128];
   logic [15:0] exp_mem [128];
   logic        sticky_m;
   logic [22:0] wq [$];
   int          total, bad;

   spi_crc_target u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata));

   assign rf_rdata = mem[rf_addr];
   always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

   function automatic logic [3:0] ref_crc(input logic [31:0] f);
      logic [31:0] p;
      logic [3:0]  c;
      logic        t;
      p = {f[31:4], 4'b0000};
      c = 4'hF;
      for (int i = 31; i >= 0; i--) begin
         t = p[i] ^ c[3];
         c = {c[2], c[1], c[0] ^ t, t};
      end
      return c;
   endfunction

   function automatic logic [31:0] mk(input logic rd, input logic [6:0] a,
                                      input logic [15:0] d, input logic [3:0] cmd);
      logic [31:0] b;
      b = {rd, a, d, cmd, 4'b0000};
      return {b[31:4], ref_crc(b)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every write strobe must match a queued expectation
   always @(posedge clk) begin
      if (rst_n && rf_we) begin
         if (wq.size() == 0) begin
            total++; bad++;
            $display("FAIL R4 unexpected write act=%h exp=none", {rf_addr, rf_wdata});
         end else begin
            chk("R3 committed write", {9'b0, rf_addr, rf_wdata}, {9'b0, wq.pop_front()});
         end
      end
   end

   task automatic spi_frame(input logic [31:0] f, input int nclk, output logic [31:0] r);
      r = '0;
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nclk; i++) begin
         sdi = (i < 32) ? f[31-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i < 32) r[31-i] = sdo;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      sdi  = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   // driver: predicts response and side effects, pushes writes, checks response
   task automatic run(input logic [31:0] f, input string tag);
      logic [31:0] body, expr, r;
      logic [3:0]  c;
      logic        err, inv;
      body = {7'b0, sticky_m, (f[31] ? exp_mem[f[30:24]] : 16'h0000), 8'h00};
      c    = ref_crc(body);
      err  = (f[3:0] != ref_crc(f));
      inv  = (f[3:1] != ref_crc(f)[3:1]);
      expr = {body[31:4], c[3:1], c[0] ^ inv};
      if (err) sticky_m = 1'b1;
      else if (!f[31]) begin
         wq.push_back({f[30:24], f[23:8]});
         exp_mem[f[30:24]] = f[23:8];
      end else if (body[24]) sticky_m = 1'b0;
      spi_frame(f, 32, r);
      chk({tag, " response"}, r, expr);
      chk({tag, " R3 R4 queue drained"}, wq.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      total = 0; bad = 0; sticky_m = 1'b0;
      for (int i = 0; i < 128; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 sdo after reset", {31'b0, sdo}, 0);
      chk("R11 rf_we after reset", {31'b0, rf_we}, 0);

      // R3 good writes, R6 status zero, R5 write returns zero data
      run(mk(1'b0, 7'h05, 16'h1234, 4'h0), "R3 R6 write 05");
      run(mk(1'b0, 7'h7F, 16'hBEEF, 4'hA), "R3 R1 write 7F cmd ignored");
      // R5 R2 read-back
      run(mk(1'b1, 7'h05, 16'h0000, 4'h0), "R5 R2 read 05");
      run(mk(1'b1, 7'h7F, 16'hFFFF, 4'h5), "R5 read 7F");
      // R4 R7 bad CRC in bit 2: dropped write, inverted response LSB
      run(mk(1'b0, 7'h05, 16'hDEAD, 4'h0) ^ 32'h4, "R4 R7 corrupt write");
      // R8 next read reports the flag, R9 passing read clears it
      run(mk(1'b1, 7'h05, 16'h0000, 4'h0), "R8 R9 read reports flag");
      run(mk(1'b1, 7'h7F, 16'h0000, 4'h0), "R9 flag cleared");
      // R7 bit-0-only mismatch: no inversion, still R8 and R4
      run(mk(1'b0, 7'h10, 16'h0F0F, 4'h0) ^ 32'h1, "R7 R8 lsb-only fault");
      // R9 write does not clear the flag
      run(mk(1'b0, 7'h11, 16'hC3C3, 4'h0), "R9 write keeps flag");
      // R9 failing read keeps flag, R7 inversion on a read
      run(mk(1'b1, 7'h11, 16'h0000, 4'h0) ^ 32'h2, "R9 R7 corrupt read");
      run(mk(1'b1, 7'h11, 16'h0000, 4'h0), "R9 read clears flag");
      run(mk(1'b1, 7'h10, 16'h0000, 4'h0), "R4 dropped address unchanged");

      // R10 aborted frame at 16 clocks
      spi_frame(mk(1'b0, 7'h05, 16'h5555, 4'h0), 16, r);
      chk("R10 abort no write", wq.size(), 0);
      run(mk(1'b1, 7'h05, 16'h0000, 4'h0), "R10 after abort data and flag");

      // mixed data patterns
      for (int k = 0; k < 6; k++)
         run(mk(1'b0, 7'(k * 19 + 3), 16'(16'h1111 * k) ^ 16'hA5C3, 4'(k)), "R3 pattern write");
      for (int k = 0; k < 6; k++)
         run(mk(1'b1, 7'(k * 19 + 3), 16'h0000, 4'(k)), "R5 pattern read");

      repeat (10) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule